// File: doc/BRIEF.md
# Command Ring Read Engine

This block drains a circular ring of 32-bit command words held in an internal memory. Software fills ring slots and advances a write pointer over a small register bus. While the run bit is set, the engine compares its own read pointer with the write pointer. It fetches the slot after the read pointer and presents it on a ready/valid output stream. The read pointer moves forward by one, wrapping at the selected ring size, only when the consumer accepts the word. The top four bits of each word name the target codec and are also given on a port of their own.

The read pointer is cleared through a handshake. Software sets the pointer-reset bit while the engine is stopped, the engine answers by showing that bit as set with the pointer at zero, and software then writes zero to release it. Clearing the run bit stops fetching, and the run bit keeps reading as one until any word already offered has been taken. While the power-down input is high, register reads return all ones, writes are dropped and no fetch starts.

Top module: `cmdring_engine`

## Requirements
- R1: After reset the write pointer (0x100) and read pointer (0x101) read 0x0000, the size register (0x102) reads 2, the control register (0x103) reads 0 and cmd_valid is low.
- R2: While run (0x103 bit 0) is set and the read pointer differs from the write pointer, the engine offers the slot at read pointer plus one, with wrap. The read pointer advances by one only when cmd_valid and cmd_ready are both high, and words leave in slot order.
- R3: Once cmd_valid is high it stays high, and cmd_data stays unchanged, until cmd_ready is high.
- R4: cmd_codec always equals bits 31:28 of cmd_data.
- R5: Size code 0 selects 2 slots, code 1 selects 16 slots and code 2 selects 256 slots. Pointers wrap at that size. A write of code 3 leaves the size register unchanged.
- R6: A ring in which write pointer plus one equals the read pointer holds size minus one commands, and the engine delivers all of them.
- R7: Writing 0x101 with bit 15 set while the engine is stopped makes the register read 0x8000 two clocks after the write edge. A later write with bit 15 clear makes it read 0x0000. The same write while running leaves the pointer and bit 15 unchanged.
- R8: After run is cleared no new word is fetched, and 0x103 bit 0 reads 1 until the word already offered is accepted.
- R9: While pwr_down is high every register read returns 0xFFFF, register and ring writes are ignored, and no fetch begins.
- R10: A write-pointer write keeps only the bits that index the selected ring size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Powered-down state: reads all ones, writes and fetch blocked |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | PTR_W+1 | Top bit clear: ring slot index; top bit set: register select in bits 1:0 |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | REG_W | Read data for bus_addr (combinational) |
| cmd_valid | output | 1 | Command word offered |
| cmd_ready | input | 1 | Consumer accepts the offered word |
| cmd_data | output | DATA_W | Command word |
| cmd_codec | output | 4 | Target codec address, bits 31:28 of the word |

## Verification
The bench builds the block with its default parameters: 256 slots, 32-bit words, 16-bit registers and a registered memory read. All three size codes are therefore legal. Switching to the 16-slot code makes both the wrap and a completely full ring reachable within a few dozen cycles. The 256-slot default still exercises reset values and the pointer masking of out-of-range write-pointer values.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

   typedef enum logic [1:0] {
      SEL_WPTR = 2'd0,
      SEL_RPTR = 2'd1,
      SEL_SIZE = 2'd2,
      SEL_CTRL = 2'd3
   } reg_sel_e;

   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_SEND = 1'b1
   } eng_state_e;

   localparam int NUM_SIZE_CODES = 3;

   // log2 of the ring size selected by a size code; 0 marks a reserved code
   function automatic int size_log2(input int code);
      case (code)
         0:       return 1;
         1:       return 4;
         2:       return 8;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/cmdring_mem.sv
module cmdring_mem #(
   parameter int DATA_W   = 32,
   parameter int PTR_W    = 8,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << PTR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_idx] <= wr_data;
   end

   generate
      if (READ_REG) begin : g_sync_read
         // word captured at fetch time; later slot writes do not disturb it
         logic [DATA_W-1:0] q_r;
         always_ff @(posedge clk) begin
            if (rd_en) q_r <= store[rd_idx];
         end
         assign rd_data = q_r;
      end else begin : g_comb_read
         // only the index is held; the slot is read through
         logic [PTR_W-1:0] idx_r;
         always_ff @(posedge clk) begin
            if (rd_en) idx_r <= rd_idx;
         end
         assign rd_data = store[idx_r];
      end
   endgenerate

endmodule

// File: rtl/cmdring_fetch.sv
module cmdring_fetch
   import cmdring_pkg::*;
#(
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fetch_en,
   input  logic [PTR_W-1:0] wr_ptr,
   input  logic [PTR_W-1:0] ptr_mask,
   input  logic             rp_clear,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [PTR_W-1:0] rd_ptr,
   output logic             busy,
   output logic             rd_en,
   output logic [PTR_W-1:0] rd_idx
);
   eng_state_e       state_q;
   logic [PTR_W-1:0] rp_q;
   logic             has_work;

   assign rd_idx   = (rp_q + 1'b1) & ptr_mask;
   assign has_work = (rp_q != wr_ptr);
   assign rd_en    = (state_q == ENG_IDLE) && fetch_en && has_work && !rp_clear;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         rp_q    <= '0;
      end else begin
         if (rp_clear) begin
            rp_q <= '0;
         end else if ((state_q == ENG_SEND) && out_ready) begin
            rp_q <= rd_idx;
         end
         case (state_q)
            ENG_IDLE: if (rd_en)     state_q <= ENG_SEND;
            ENG_SEND: if (out_ready) state_q <= ENG_IDLE;
            default:                 state_q <= ENG_IDLE;
         endcase
      end
   end

   assign out_valid = (state_q == ENG_SEND);
   assign busy      = (state_q == ENG_SEND);
   assign rd_ptr    = rp_q;

endmodule

// File: rtl/cmdring_regs.sv
module cmdring_regs
   import cmdring_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PTR_W  = 8,
   parameter int REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_down,
   input  logic              bus_wr,
   input  logic [PTR_W:0]    bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              ring_wr,
   output logic [PTR_W-1:0]  ring_idx,
   output logic [DATA_W-1:0] ring_data,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic [PTR_W-1:0]  ptr_mask,
   output logic              run_req,
   output logic              rp_clear,
   output logic              rp_ack,
   input  logic [PTR_W-1:0]  rd_ptr,
   input  logic              eng_busy
);
   localparam int RST_BIT = REG_W - 1;
   localparam logic [1:0] DEF_CODE = (PTR_W >= 8) ? 2'd2 : (PTR_W >= 4) ? 2'd1 : 2'd0;

   logic [PTR_W-1:0] mask_tbl [4];
   logic [3:0]       code_ok;

   generate
      for (genvar c = 0; c < 4; c++) begin : g_code
         localparam int LG = size_log2(c);
         localparam bit OK = (c < NUM_SIZE_CODES) && (LG > 0) && (LG <= PTR_W);
         assign code_ok[c]  = OK;
         assign mask_tbl[c] = OK ? PTR_W'((1 << LG) - 1) : '1;
      end
   endgenerate

   logic [PTR_W-1:0] wp_q;
   logic [1:0]       size_q;
   logic             run_q;
   logic             rst_req_q;
   logic             ack_q;
   logic             wr_ok;
   logic             reg_hit;
   logic             stopped;
   reg_sel_e         sel;

   assign sel      = reg_sel_e'(bus_addr[1:0]);
   assign wr_ok    = bus_wr && !pwr_down;
   assign reg_hit  = wr_ok && bus_addr[PTR_W];
   assign stopped  = !run_q && !eng_busy;
   assign ptr_mask = mask_tbl[size_q];

   assign ring_wr   = wr_ok && !bus_addr[PTR_W];
   assign ring_idx  = bus_addr[PTR_W-1:0];
   assign ring_data = bus_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q      <= '0;
         size_q    <= DEF_CODE;
         run_q     <= 1'b0;
         rst_req_q <= 1'b0;
         ack_q     <= 1'b0;
      end else begin
         rst_req_q <= 1'b0;
         if (rst_req_q) ack_q <= 1'b1;
         if (reg_hit) begin
            case (sel)
               SEL_WPTR: wp_q <= bus_wdata[PTR_W-1:0] & ptr_mask;
               SEL_RPTR: begin
                  if (bus_wdata[RST_BIT]) begin
                     if (stopped) rst_req_q <= 1'b1;
                  end else if (!rst_req_q) begin
                     ack_q <= 1'b0;
                  end
               end
               SEL_SIZE: if (code_ok[bus_wdata[1:0]]) size_q <= bus_wdata[1:0];
               SEL_CTRL: run_q <= bus_wdata[0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (pwr_down) begin
         bus_rdata = '1;
      end else if (bus_addr[PTR_W]) begin
         case (sel)
            SEL_WPTR: bus_rdata = REG_W'(wp_q);
            SEL_RPTR: bus_rdata = {ack_q, (REG_W-1)'(rd_ptr)};
            SEL_SIZE: bus_rdata = REG_W'(size_q);
            SEL_CTRL: bus_rdata = REG_W'(!stopped);
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign wr_ptr   = wp_q;
   assign run_req  = run_q;
   assign rp_clear = rst_req_q;
   assign rp_ack   = ack_q;

endmodule

// File: rtl/cmdring_engine.sv
module cmdring_engine #(
   parameter int DATA_W   = 32,
   parameter int PTR_W    = 8,
   parameter int REG_W    = 16,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_down,
   input  logic              bus_wr,
   input  logic [PTR_W:0]    bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [DATA_W-1:0] cmd_data,
   output logic [3:0]        cmd_codec
);
   generate
      if (PTR_W < 2 || PTR_W > REG_W - 2) begin : g_bad_ptr
         $error("cmdring_engine: PTR_W must lie between 2 and REG_W-2");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("cmdring_engine: DATA_W must be at least 8");
      end
   endgenerate

   logic              ring_wr;
   logic [PTR_W-1:0]  ring_idx;
   logic [DATA_W-1:0] ring_data;
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;
   logic [PTR_W-1:0]  ptr_mask;
   logic              run_req;
   logic              rp_clear;
   logic              rp_ack;
   logic              eng_busy;
   logic              fetch_en;
   logic              rd_en;
   logic [PTR_W-1:0]  rd_idx;

   assign fetch_en = run_req && !pwr_down;

   cmdring_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W), .REG_W(REG_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_down  (pwr_down),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ring_wr   (ring_wr),
      .ring_idx  (ring_idx),
      .ring_data (ring_data),
      .wr_ptr    (wr_ptr),
      .ptr_mask  (ptr_mask),
      .run_req   (run_req),
      .rp_clear  (rp_clear),
      .rp_ack    (rp_ack),
      .rd_ptr    (rd_ptr),
      .eng_busy  (eng_busy)
   );

   cmdring_fetch #(.PTR_W(PTR_W)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .fetch_en  (fetch_en),
      .wr_ptr    (wr_ptr),
      .ptr_mask  (ptr_mask),
      .rp_clear  (rp_clear),
      .out_ready (cmd_ready),
      .out_valid (cmd_valid),
      .rd_ptr    (rd_ptr),
      .busy      (eng_busy),
      .rd_en     (rd_en),
      .rd_idx    (rd_idx)
   );

   cmdring_mem #(.DATA_W(DATA_W), .PTR_W(PTR_W), .READ_REG(READ_REG)) u_mem (
      .clk     (clk),
      .wr_en   (ring_wr),
      .wr_idx  (ring_idx),
      .wr_data (ring_data),
      .rd_en   (rd_en),
      .rd_idx  (rd_idx),
      .rd_data (cmd_data)
   );

   assign cmd_codec = cmd_data[DATA_W-1 -: 4];

endmodule

// File: rtl/cmdring_chk.sv
module cmdring_chk #(
   parameter int DATA_W = 32,
   parameter int PTR_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwr_down,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [DATA_W-1:0] cmd_data,
   input logic [PTR_W-1:0]  rd_ptr,
   input logic [PTR_W-1:0]  wr_ptr,
   input logic              run_req,
   input logic              rp_clear,
   input logic              rp_ack
);
   // R3: offered word is held until taken
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

   // R2: read pointer moves only on a completed handshake or a pointer reset
   assert_rp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_ptr) |-> $past(cmd_valid && cmd_ready) || $past(rp_clear));

   // R2: a fetch starts only when pointers differ
   assert_fetch_work_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid) |-> $past(rd_ptr != wr_ptr));

   // R8: no fetch starts without the run request
   assert_run_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid) |-> $past(run_req));

   // R9: no fetch starts while powered down
   assert_no_fetch_pd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid) |-> !$past(pwr_down));

   // R7: acknowledge appears together with a zero pointer
   assert_ack_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rp_ack) |-> rd_ptr == '0);

endmodule

bind cmdring_engine cmdring_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_down  (pwr_down),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_data  (cmd_data),
   .rd_ptr    (rd_ptr),
   .wr_ptr    (wr_ptr),
   .run_req   (run_req),
   .rp_clear  (rp_clear),
   .rp_ack    (rp_ack)
);

// File: tb/test_cmdring_engine.sv
module test_cmdring_engine;
   localparam int DATA_W = 32;
   localparam int PTR_W  = 8;
   localparam int REG_W  = 16;

   localparam logic [8:0] A_WP = 9'h100;
   localparam logic [8:0] A_RP = 9'h101;
   localparam logic [8:0] A_SZ = 9'h102;
   localparam logic [8:0] A_CT = 9'h103;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pwr_down = 1'b0;
   logic              bus_wr = 1'b0;
   logic [8:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [15:0]       bus_rdata;
   logic              cmd_valid;
   logic              cmd_ready = 1'b0;
   logic [31:0]       cmd_data;
   logic [3:0]        cmd_codec;

   cmdring_engine #(.DATA_W(DATA_W), .PTR_W(PTR_W), .REG_W(REG_W)) i_cmdring_engine (
      .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
      .cmd_codec(cmd_codec)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int          m_wp, m_rp, m_size, m_run, m_send, m_rstreq, m_ack;
   int          n_wp, n_rp, n_size, n_run, n_send, n_rstreq, n_ack;
   int          msk;
   bit          stopped;
   logic [31:0] m_data, n_data, e_word;
   logic [31:0] m_mem [256];
   logic [31:0] exp_q [$];

   function automatic int mask_of(input int code);
      case (code)
         0: return 1;
         1: return 15;
         default: return 255;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_wp = 0; m_rp = 0; m_size = 2; m_run = 0;
         m_send = 0; m_rstreq = 0; m_ack = 0; m_data = '0;
      end else begin
         chk("R3 per-cycle valid", {31'b0, cmd_valid}, {31'b0, m_send[0]});
         if (m_send != 0) begin
            chk("R2 per-cycle data", cmd_data, m_data);
            chk("R4 codec field", {28'b0, cmd_codec}, {28'b0, m_data[31:28]});
         end
         if (cmd_valid && cmd_ready) begin
            if (exp_q.size() == 0) chk("R2 unexpected word", cmd_data, 32'hDEAD_BEEF);
            else begin
               e_word = exp_q.pop_front();
               chk("R2 delivery order", cmd_data, e_word);
            end
         end
         msk = mask_of(m_size);
         stopped = (m_run == 0) && (m_send == 0);
         n_wp = m_wp; n_rp = m_rp; n_size = m_size; n_run = m_run;
         n_send = m_send; n_rstreq = 0; n_ack = m_ack; n_data = m_data;
         if (m_rstreq != 0) begin
            n_rp = 0; n_ack = 1;
         end else if (m_send != 0) begin
            if (cmd_ready) begin n_send = 0; n_rp = (m_rp + 1) & msk; end
         end else if (m_run != 0 && !pwr_down && m_rp != m_wp) begin
            n_send = 1; n_data = m_mem[(m_rp + 1) & msk];
         end
         if (bus_wr && !pwr_down) begin
            if (!bus_addr[8]) m_mem[bus_addr[7:0]] = bus_wdata;
            else case (bus_addr[1:0])
               2'd0: n_wp = int'(bus_wdata[7:0]) & msk;
               2'd1: begin
                  if (bus_wdata[15]) begin
                     if (stopped) n_rstreq = 1;
                  end else if (m_rstreq == 0) n_ack = 0;
               end
               2'd2: if (bus_wdata[1:0] != 2'd3) n_size = int'(bus_wdata[1:0]);
               default: n_run = int'(bus_wdata[0]);
            endcase
         end
         m_wp = n_wp; m_rp = n_rp; m_size = n_size; m_run = n_run;
         m_send = n_send; m_rstreq = n_rstreq; m_ack = n_ack; m_data = n_data;
      end
   end

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [8:0] a, input logic [15:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, {16'b0, bus_rdata}, {16'b0, exp});
   endtask

   task automatic put(input int idx, input logic [31:0] d);
      wr({1'b0, 8'(idx)}, d);
      exp_q.push_back(d);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] held;
      wait_cyc(5);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk("R1 write pointer", A_WP, 16'h0000);
      rd_chk("R1 read pointer", A_RP, 16'h0000);
      rd_chk("R1 size code", A_SZ, 16'h0002);
      rd_chk("R1 control", A_CT, 16'h0000);
      chk("R1 valid low", {31'b0, cmd_valid}, 32'h0);

      // R2 basic drain
      cmd_ready = 1'b1;
      for (int i = 1; i <= 5; i++) put(i, {4'(i), 28'h0ABC000 + 28'(i)});
      wr(A_WP, 32'd5);
      wr(A_CT, 32'd1);
      wait_cyc(20);
      rd_chk("R2 pointer after drain", A_RP, 16'h0005);

      // R3 backpressure, R4 codec
      cmd_ready = 1'b0;
      put(6, 32'h3000_0066);
      put(7, 32'h7000_0077);
      wr(A_WP, 32'd7);
      wait_cyc(4);
      chk("R3 valid under backpressure", {31'b0, cmd_valid}, 32'h1);
      held = cmd_data;
      chk("R3 offered word", held, 32'h3000_0066);
      wait_cyc(3);
      chk("R3 word stable", cmd_data, held);
      chk("R4 codec port", {28'b0, cmd_codec}, 32'h3);
      cmd_ready = 1'b1;
      wait_cyc(6);
      rd_chk("R2 pointer after backpressure", A_RP, 16'h0007);

      // R8 stop with a word pending
      cmd_ready = 1'b0;
      put(8, 32'hA000_0088);
      wr(A_WP, 32'd8);
      wait_cyc(3);
      wr(A_CT, 32'd0);
      rd_chk("R8 run reads set while busy", A_CT, 16'h0001);
      cmd_ready = 1'b1;
      wait_cyc(2);
      rd_chk("R8 run reads clear when stopped", A_CT, 16'h0000);
      wr({1'b0, 8'd9}, 32'h5000_0099);
      wr(A_WP, 32'd9);
      wait_cyc(6);
      chk("R8 no fetch after stop", {31'b0, cmd_valid}, 32'h0);
      rd_chk("R8 pointer held", A_RP, 16'h0008);

      // R7 pointer reset handshake
      exp_q.push_back(32'h5000_0099);
      wr(A_CT, 32'd1);
      wait_cyc(6);
      wr(A_RP, 32'h0000_8000);
      wait_cyc(2);
      rd_chk("R7 reset ignored while running", A_RP, 16'h0009);
      wr(A_CT, 32'd0);
      wait_cyc(3);
      wr(A_RP, 32'h0000_8000);
      rd_chk("R7 acknowledge with zero pointer", A_RP, 16'h8000);
      wr(A_RP, 32'h0000_0000);
      rd_chk("R7 release reads zero", A_RP, 16'h0000);
      wr(A_WP, 32'd0);
      rd_chk("R7 write pointer zero", A_WP, 16'h0000);

      // R5 / R6 / R10 sizes, full ring, wrap, masking
      wr(A_SZ, 32'd1);
      wr(A_SZ, 32'd3);
      rd_chk("R5 reserved code ignored", A_SZ, 16'h0001);
      for (int i = 1; i <= 15; i++) put(i, {4'(i), 28'(i * 3)});
      wr(A_WP, 32'd15);
      rd_chk("R6 full ring pointer", A_WP, 16'h000F);
      wr(A_CT, 32'd1);
      wait_cyc(40);
      rd_chk("R6 full ring drained", A_RP, 16'h000F);
      put(0, 32'hC000_0100);
      put(1, 32'hC100_0101);
      put(2, 32'hC200_0102);
      wr(A_WP, 32'd2);
      wait_cyc(12);
      rd_chk("R5 wrap at 16 slots", A_RP, 16'h0002);
      put(3, 32'hD000_0103);
      wr(A_WP, 32'h0000_01F3);
      rd_chk("R10 pointer masked", A_WP, 16'h0003);
      wait_cyc(8);
      rd_chk("R5 pointer after masked write", A_RP, 16'h0003);

      // R9 power down
      wr(A_CT, 32'd0);
      wait_cyc(3);
      put(4, 32'hE000_0104);
      wr(A_WP, 32'd4);
      wr(A_CT, 32'd1);
      pwr_down = 1'b1;
      rd_chk("R9 write pointer all ones", A_WP, 16'hFFFF);
      rd_chk("R9 read pointer all ones", A_RP, 16'hFFFF);
      rd_chk("R9 control all ones", A_CT, 16'hFFFF);
      wr(A_WP, 32'd9);
      wr({1'b0, 8'd4}, 32'h1111_1111);
      wait_cyc(4);
      chk("R9 no fetch while powered down", {31'b0, cmd_valid}, 32'h0);
      @(negedge clk);
      pwr_down = 1'b0;
      rd_chk("R9 write ignored", A_WP, 16'h0004);
      wait_cyc(6);
      rd_chk("R9 fetch resumes", A_RP, 16'h0004);

      wait_cyc(4);
      chk("R2 every word delivered", exp_q.size(), 32'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule